// File: doc/BRIEF.md
# Dual-converter serial output framer

This block produces the serial output side of a sampling front end with two converters. A host pulls chip select low and toggles a serial clock. Each of the two data lines then sends a 16-bit word: a fixed zero, three status bits that identify the word, and the twelve result bits, most significant first. The conversion results, the range pin level and the channel selection arrive as parallel inputs. They are latched when chip select falls. If chip select stays low for a second run of sixteen clocks, each line goes on to send the other converter's word. A single host port can then collect both results.

Chip select and the serial clock are not used as clocks. Each passes through a synchronizer into the system clock domain, and the block acts on the edges detected there. Each data line has its own output-enable flag that stands for its high-impedance state. A track flag shows whether the sampling stage is tracking or holding.

Top module: `dual_frame_tx`

## Requirements
- R1: While reset is asserted, both output-enable flags are 0 and the track flag is 1.
- R2: SYNC_STAGES+1 system clocks after chip select falls, both lines are enabled and both present the leading zero bit.
- R3: A word is, from first to last bit: 0, range bit, channel bit (0 = first channel, 1 = second), converter identity bit (0 = converter A, 1 = converter B), then result bits 11 down to 0. Line A starts with converter A's word and line B starts with converter B's word.
- R4: A line's bit changes only on a detected serial clock falling edge during a frame. The last bit of the first word is launched by the 15th falling edge.
- R5: The range bit carries the range input level captured at the previous frame's chip select fall. Before any capture it is 0.
- R6: In bits 17 to 32, line A sends converter B's word and line B sends converter A's word. Each word keeps its own identity bit.
- R7: Both lines are disabled on the 32nd detected serial clock rising edge of a frame. They stay disabled until the next chip select fall.
- R8: A chip select rise at any point in a frame disables both lines.
- R9: The track flag drops to 0 at the chip select fall. It returns to 1 on the first serial clock rising edge after 13 falling edges, or when chip select rises.
- R10: The results and the channel bit are latched at the chip select fall. Changes on those inputs during the frame do not alter the bits sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; samples chip select and serial clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| sclk_i | input | 1 | Serial clock from the host, high when idle |
| range_i | input | 1 | Input-range pin level |
| chan_i | input | 1 | Channel select, 0 = first channel |
| res_a_i | input | DATA_W | Converter A result |
| res_b_i | input | DATA_W | Converter B result |
| sd_a_o | output | 1 | Line A serial bit |
| sd_a_oe_o | output | 1 | Line A driven (0 = high impedance) |
| sd_b_o | output | 1 | Line B serial bit |
| sd_b_oe_o | output | 1 | Line B driven (0 = high impedance) |
| track_o | output | 1 | 1 = tracking, 0 = holding |

## Verification
The bench builds the block with DATA_W = 12, TRACK_FALLS = 13 and SYNC_STAGES = 3. These values give the full 32-bit two-word frame and put the track point at the 13th falling edge. Using three synchronizer stages instead of the default two tests that every output delay follows the stage count. The reference model works in terms of detected edges, so the 16-clock, 32-clock, over-length and aborted frames can all be compared bit for bit at that depth.

// File: rtl/framer_pkg.sv
package framer_pkg;
  localparam int unsigned HDR_W = 4;
  localparam logic ID_A = 1'b0;
  localparam logic ID_B = 1'b1;

  typedef struct packed {
    logic rise;
    logic fall;
  } edge_t;
endpackage

// File: rtl/framer_edge_sync.sv
module framer_edge_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                d_i,
  output framer_pkg::edge_t   e_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;
  logic              lvl;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= RST_VAL;
        else         chain_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign lvl = chain_q[STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= RST_VAL;
    else         prev_q <= lvl;
  end

  assign e_o.rise = lvl & ~prev_q;
  assign e_o.fall = ~lvl & prev_q;
endmodule

// File: rtl/framer_lane.sv
module framer_lane #(
  parameter int unsigned FRAME_BITS = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  load_i,
  input  logic                  shift_i,
  input  logic [FRAME_BITS-1:0] word_i,
  output logic                  sd_o
);
  logic [FRAME_BITS-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (load_i)  sr_q <= word_i;
    else if (shift_i) sr_q <= {sr_q[FRAME_BITS-2:0], 1'b0};
  end

  assign sd_o = sr_q[FRAME_BITS-1];
endmodule

// File: rtl/framer_ctrl.sv
module framer_ctrl #(
  parameter int unsigned FRAME_BITS  = 32,
  parameter int unsigned TRACK_FALLS = 13
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  framer_pkg::edge_t  cs_e_i,
  input  framer_pkg::edge_t  sclk_e_i,
  output logic               shift_o,
  output logic               en_o,
  output logic               track_o
);
  localparam int unsigned CNT_W = $clog2(FRAME_BITS + 1);

  logic             active_q;
  logic [CNT_W-1:0] fcnt_q, rcnt_q;

  // cs_e_i.fall is chip select going low (frame start)
  assign shift_o = active_q & sclk_e_i.fall & ~cs_e_i.fall & ~cs_e_i.rise
                 & (fcnt_q < CNT_W'(FRAME_BITS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      fcnt_q   <= '0;
      rcnt_q   <= '0;
      en_o     <= 1'b0;
      track_o  <= 1'b1;
    end else if (cs_e_i.fall) begin
      active_q <= 1'b1;
      fcnt_q   <= '0;
      rcnt_q   <= '0;
      en_o     <= 1'b1;
      track_o  <= 1'b0;
    end else if (cs_e_i.rise) begin
      active_q <= 1'b0;
      en_o     <= 1'b0;
      track_o  <= 1'b1;
    end else if (active_q) begin
      if (shift_o) fcnt_q <= fcnt_q + 1'b1;
      if (sclk_e_i.rise) begin
        if (rcnt_q < CNT_W'(FRAME_BITS)) rcnt_q <= rcnt_q + 1'b1;
        if (rcnt_q == CNT_W'(FRAME_BITS - 1)) en_o <= 1'b0;
        if (fcnt_q >= CNT_W'(TRACK_FALLS)) track_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dual_frame_tx.sv
module dual_frame_tx #(
  parameter int unsigned DATA_W      = 12,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned TRACK_FALLS = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic              range_i,
  input  logic              chan_i,
  input  logic [DATA_W-1:0] res_a_i,
  input  logic [DATA_W-1:0] res_b_i,
  output logic              sd_a_o,
  output logic              sd_a_oe_o,
  output logic              sd_b_o,
  output logic              sd_b_oe_o,
  output logic              track_o
);
  import framer_pkg::*;

  localparam int unsigned WORD_W     = DATA_W + HDR_W;
  localparam int unsigned FRAME_BITS = 2 * WORD_W;

  edge_t cs_e, sclk_e;
  logic  cs_fall, cs_rise, sclk_fall;
  logic  shift, en, range_q;
  logic  [WORD_W-1:0] word [2];
  logic  [1:0] sd;

  framer_edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(cs_ni), .e_o(cs_e)
  );
  framer_edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sclk_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sclk_i), .e_o(sclk_e)
  );

  assign cs_fall   = cs_e.fall;
  assign cs_rise   = cs_e.rise;
  assign sclk_fall = sclk_e.fall;

  framer_ctrl #(.FRAME_BITS(FRAME_BITS), .TRACK_FALLS(TRACK_FALLS)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_e_i(cs_e), .sclk_e_i(sclk_e),
    .shift_o(shift), .en_o(en), .track_o(track_o)
  );

  // range bit reports the level captured at the previous frame start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      range_q <= 1'b0;
    else if (cs_fall) range_q <= range_i;
  end

  assign word[0] = {1'b0, range_q, chan_i, ID_A, res_a_i};
  assign word[1] = {1'b0, range_q, chan_i, ID_B, res_b_i};

  generate
    for (genvar g = 0; g < 2; g++) begin : g_lane
      framer_lane #(.FRAME_BITS(FRAME_BITS)) u_lane (
        .clk_i(clk_i), .rst_ni(rst_ni), .load_i(cs_fall), .shift_i(shift),
        .word_i({word[g], word[1-g]}), .sd_o(sd[g])
      );
    end
  endgenerate

  assign sd_a_o    = sd[0];
  assign sd_b_o    = sd[1];
  assign sd_a_oe_o = en;
  assign sd_b_oe_o = en;
endmodule

// File: rtl/framer_checker.sv
module framer_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_fall_i,
  input logic cs_rise_i,
  input logic sclk_fall_i,
  input logic sd_a_i,
  input logic sd_b_i,
  input logic oe_a_i,
  input logic oe_b_i,
  input logic track_i
);
  assert_capture_enable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_fall_i |=> (oe_a_i && oe_b_i && !sd_a_i && !sd_b_i));

  assert_bit_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sclk_fall_i && !cs_fall_i) |=> ($stable(sd_a_i) && $stable(sd_b_i)));

  assert_stay_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!oe_a_i && !cs_fall_i) |=> !oe_a_i);

  assert_release_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_rise_i |=> (!oe_a_i && !oe_b_i));

  assert_hold_on_capture_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_fall_i |=> !track_i);
endmodule

bind dual_frame_tx framer_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_fall_i(cs_fall), .cs_rise_i(cs_rise),
  .sclk_fall_i(sclk_fall), .sd_a_i(sd_a_o), .sd_b_i(sd_b_o),
  .oe_a_i(sd_a_oe_o), .oe_b_i(sd_b_oe_o), .track_i(track_o)
);

// File: tb/test_dual_frame_tx.sv
`timescale 1ns/1ps
module test_dual_frame_tx;
  localparam int DW   = 12;
  localparam int SYNC = 3;
  localparam int TRKF = 13;
  localparam int FB   = 2 * (DW + 4);
  localparam int HALF = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b1, rng = 1'b0, chan = 1'b0;
  logic [DW-1:0] res_a = '0, res_b = '0;
  logic sd_a, sd_a_oe, sd_b, sd_b_oe, trk;

  dual_frame_tx #(.DATA_W(DW), .SYNC_STAGES(SYNC), .TRACK_FALLS(TRKF)) i_dual_frame_tx (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk), .range_i(rng),
    .chan_i(chan), .res_a_i(res_a), .res_b_i(res_b), .sd_a_o(sd_a),
    .sd_a_oe_o(sd_a_oe), .sd_b_o(sd_b), .sd_b_oe_o(sd_b_oe), .track_o(trk)
  );

  always #4 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  string scen = "R1";

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s/%s: actual %0d expected %0d at %0t", scen, req, act, exp, $time);
    end
  endtask

  // behavioural reference working on delayed input history
  bit h_cs [0:SYNC];
  bit h_sc [0:SYNC];
  bit [FB-1:0] seq_a, seq_b;
  int f, r;
  bit act, e_oe, e_trk, prev_rng;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k <= SYNC; k++) begin h_cs[k] = 1; h_sc[k] = 1; end
      act = 0; f = 0; r = 0; e_oe = 0; e_trk = 1; prev_rng = 0;
      seq_a = '0; seq_b = '0;
    end else begin
      bit cf, cr, sf, sr;
      cf = h_cs[SYNC] && !h_cs[SYNC-1];
      cr = !h_cs[SYNC] && h_cs[SYNC-1];
      sf = h_sc[SYNC] && !h_sc[SYNC-1];
      sr = !h_sc[SYNC] && h_sc[SYNC-1];
      if (cf) begin
        seq_a = {1'b0, prev_rng, chan, 1'b0, res_a, 1'b0, prev_rng, chan, 1'b1, res_b};
        seq_b = {1'b0, prev_rng, chan, 1'b1, res_b, 1'b0, prev_rng, chan, 1'b0, res_a};
        prev_rng = rng;
        act = 1; f = 0; r = 0; e_oe = 1; e_trk = 0;
      end else if (cr) begin
        act = 0; e_oe = 0; e_trk = 1;
      end else if (act) begin
        if (sf && f < FB) f++;
        if (sr) begin
          if (r < FB) r++;
          if (r == FB) e_oe = 0;
          if (f >= TRKF) e_trk = 1;
        end
      end
      for (int k = SYNC; k > 0; k--) begin h_cs[k] = h_cs[k-1]; h_sc[k] = h_sc[k-1]; end
      h_cs[0] = cs_n; h_sc[0] = sclk;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit ea, eb;
      ea = (f < FB) ? seq_a[FB-1-f] : 1'b0;
      eb = (f < FB) ? seq_b[FB-1-f] : 1'b0;
      chk(sd_a_oe == e_oe, "R7 oe A", sd_a_oe, e_oe);
      chk(sd_b_oe == e_oe, "R8 oe B", sd_b_oe, e_oe);
      chk(trk == e_trk, "R9 track", trk, e_trk);
      if (e_oe) begin
        chk(sd_a == ea, "R4 bit A", sd_a, ea);
        chk(sd_b == eb, "R4 bit B", sd_b, eb);
      end
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clocks(input int n);
    for (int i = 0; i < n; i++) begin
      sclk = 1'b0; wait_n(HALF);
      sclk = 1'b1; wait_n(HALF);
    end
  endtask

  task automatic cs_low();
    cs_n = 1'b0; wait_n(HALF);
  endtask

  task automatic cs_high();
    cs_n = 1'b1; wait_n(2 * HALF + SYNC);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    wait_n(3);
    scen = "R1";
    chk(sd_a_oe == 1'b0, "R1 oe A", sd_a_oe, 0);
    chk(sd_b_oe == 1'b0, "R1 oe B", sd_b_oe, 0);
    chk(trk == 1'b1, "R1 track", trk, 1);
    rst_n = 1'b1;
    wait_n(6);

    scen = "R2";
    rng = 1'b1; chan = 1'b0; res_a = 12'hA5C; res_b = 12'h3F1;
    cs_low(); clocks(16); cs_high();

    scen = "R3";
    rng = 1'b0; chan = 1'b1; res_a = 12'h0F0; res_b = 12'hC33;
    cs_low(); clocks(16); cs_high();

    scen = "R5";
    rng = 1'b1; chan = 1'b0; res_a = 12'hFFF; res_b = 12'h000;
    cs_low(); clocks(16); cs_high();

    scen = "R6";
    rng = 1'b0; chan = 1'b1; res_a = 12'h5A3; res_b = 12'h9C6;
    cs_low(); clocks(34); cs_high();

    scen = "R10";
    rng = 1'b1; chan = 1'b0; res_a = 12'h123; res_b = 12'hABC;
    cs_low(); clocks(6);
    chan = 1'b1; res_a = 12'hEDC; res_b = 12'h456; rng = 1'b0;
    clocks(26); cs_high();

    scen = "R8";
    rng = 1'b1; res_a = 12'h777; res_b = 12'h888;
    cs_low(); clocks(5); cs_high();
    cs_low(); clocks(14); cs_high();

    scen = "R9";
    chan = 1'b0; res_a = 12'h001; res_b = 12'h800;
    cs_low(); clocks(13); wait_n(10); clocks(3); cs_high();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule